// File: doc/BRIEF.md
# Power Mode Sequencer

This block steers a small chip between three power modes: Operating, Idle and Standby. Software asks for Idle or Standby by pulsing one of two write strobes, which a register decoder outside the block produces. Hardware can force Standby at any time through two active-low inputs, one for supply failure and one for a user reset button. From Standby the chip wakes on a rising edge of an asynchronous wake input. The wake is taken only when the supply-health inputs show that there is enough power.

A wake-up that is accepted does not hand control to the CPU at once. The block first enters a settle phase: the CPU clock is enabled, the CPU is kept in reset, and a counter runs for a fixed number of cycles so the clock can stabilise. Only then is the CPU released. Combinational decodes of the current mode drive four outputs: a CPU clock enable, a peripheral-domain enable, a DRAM self-refresh request and the CPU reset. A 2-bit code reports the current mode.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, the block is in Standby: mode code 10, CPU reset 1, DRAM self-refresh 1, CPU clock enable 0, peripheral enable 0.
- R2: A low level on the power-fail input or on the user-reset input, sampled at a rising clock edge, puts the block in Standby at that edge, whatever the previous mode.
- R3: Standby is left only toward Operating, through the settle phase. Idle strobes, Standby strobes and interrupts have no effect while in Standby.
- R4: A wake event is accepted only if, at the edge where it is taken, the power-fail input is high and either the external-power input (active low) is low or the battery-ok input is high. Any other wake event is dropped and the block stays in Standby.
- R5: The wake input passes through a two-flop synchroniser followed by a rising-edge detector. The block leaves Standby at the third rising clock edge after the wake input goes high. A wake input that simply stays high triggers no further wake.
- R6: The settle phase lasts exactly 8 clock cycles. During it the outputs are mode code 00, CPU reset 1, CPU clock enable 1, peripheral enable 1 and self-refresh 0. After it the block is in Operating with CPU reset 0.
- R7: In Operating, a Standby strobe moves the block to Standby at the next edge. When the Standby strobe and the Idle strobe arrive in the same cycle, the Standby strobe wins.
- R8: In Operating, an Idle strobe moves the block to Idle. In Idle the outputs are mode code 01, CPU clock enable 0, peripheral enable 1, self-refresh 0 and CPU reset 0.
- R9: Idle returns to Operating at the next edge when any interrupt is pending with its mask bit clear (mask bit 1 = masked). Interrupts that are pending but masked leave the block in Idle.
- R10: A power-fail or user-reset assertion during the settle phase cancels it. The block returns to Standby with the CPU still in reset, and a later wake restarts the full 8-cycle settle.
- R11: In Operating the outputs are mode code 00, CPU reset 0, CPU clock enable 1, peripheral enable 1 and self-refresh 0. The mode code never takes the value 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_idle_wr | input | 1 | One-cycle software strobe requesting Idle |
| sw_stby_wr | input | 1 | One-cycle software strobe requesting Standby |
| pwr_fail_n | input | 1 | Supply failure, active low, synchronous to clk |
| user_rst_n | input | 1 | User reset button, active low, synchronous to clk |
| ext_pwr_n | input | 1 | External power present, active low |
| batt_ok | input | 1 | Main battery healthy |
| wake_in | input | 1 | Asynchronous wake request, rising edge |
| irq_pend | input | IRQ_W | Pending interrupt lines |
| irq_mask | input | IRQ_W | Interrupt masks, 1 = masked |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_en | output | 1 | Peripheral-domain enable |
| dram_selfref | output | 1 | DRAM self-refresh request |
| cpu_rst | output | 1 | CPU reset, active high |
| mode_code | output | 2 | 00 Operating, 01 Idle, 10 Standby |

## Verification
Every output is decoded directly from the mode register, so a wrong mode shows on mode_code and on the enables in the same cycle the register takes the bad value. A settle counter that is off by one moves the fall of cpu_rst by a cycle, and the bench checks that edge cycle by cycle. A wrong qualification of the wake event or of the interrupt mask shows up three cycles, or one cycle, after the stimulus, as a mode that stays in Standby or Idle when it should have moved, or moves when it should have stayed.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

   // Mode register encoding. The three public modes map straight onto
   // the reported code. The settle phase uses the spare code, which is
   // folded to Operating at the output.
   typedef enum logic [1:0] {
      PM_OPER = 2'b00,
      PM_IDLE = 2'b01,
      PM_STBY = 2'b10,
      PM_SETL = 2'b11
   } pm_state_t;

   typedef struct packed {
      logic       cpu_clk_en;
      logic       periph_en;
      logic       dram_selfref;
      logic       cpu_rst;
      logic [1:0] code;
   } pm_outs_t;

   function automatic pm_outs_t pm_decode(input pm_state_t st);
      pm_outs_t o;
      unique case (st)
         PM_OPER: o = '{cpu_clk_en: 1'b1, periph_en: 1'b1, dram_selfref: 1'b0,
                        cpu_rst: 1'b0, code: 2'b00};
         PM_IDLE: o = '{cpu_clk_en: 1'b0, periph_en: 1'b1, dram_selfref: 1'b0,
                        cpu_rst: 1'b0, code: 2'b01};
         PM_STBY: o = '{cpu_clk_en: 1'b0, periph_en: 1'b0, dram_selfref: 1'b1,
                        cpu_rst: 1'b1, code: 2'b10};
         PM_SETL: o = '{cpu_clk_en: 1'b1, periph_en: 1'b1, dram_selfref: 1'b0,
                        cpu_rst: 1'b1, code: 2'b00};
         default: o = '{cpu_clk_en: 1'b0, periph_en: 1'b0, dram_selfref: 1'b1,
                        cpu_rst: 1'b1, code: 2'b10};
      endcase
      return o;
   endfunction

endpackage

// File: rtl/pwr_wake_sync.sv
module pwr_wake_sync #(
   parameter int STAGES  = 2,
   parameter bit RISE_EV = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic pulse
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pwr_wake_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sr;
   logic              prev;
   logic              sync_q;

   assign sync_q = sr[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '0;
         prev <= 1'b0;
      end else begin
         sr   <= {sr[STAGES-2:0], din};
         prev <= sync_q;
      end
   end

   generate
      if (RISE_EV) begin : g_rise
         assign pulse = sync_q & ~prev;
      end else begin : g_fall
         assign pulse = ~sync_q & prev;
      end
   endgenerate

   // R5: an edge event lasts a single cycle
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);

endmodule

// File: rtl/pwr_settle_cnt.sv
module pwr_settle_cnt #(
   parameter int LIMIT = 8,
   parameter int CNT_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("pwr_settle_cnt: LIMIT must be at least 1");
      end
      if (LIMIT > (1 << CNT_W)) begin : g_bad_width
         $error("pwr_settle_cnt: CNT_W too narrow for LIMIT");
      end
   endgenerate

   localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

   logic [CNT_W-1:0] cnt;

   assign done = run && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else if (cnt != LAST) begin
         cnt <= cnt + 1'b1;
      end
   end

   // R6: the count never passes the terminal value
   a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);

   // R10: an idle counter restarts from zero
   a_r10_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> cnt == '0);

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
   import pwr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      force_stby,
   input  logic      sw_idle,
   input  logic      sw_stby,
   input  logic      wake_ok,
   input  logic      irq_hit,
   input  logic      settle_done,
   output pm_state_t state
);

   pm_state_t nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         PM_OPER: begin
            if (sw_stby)      nxt = PM_STBY;
            else if (sw_idle) nxt = PM_IDLE;
         end
         PM_IDLE: if (irq_hit)     nxt = PM_OPER;
         PM_STBY: if (wake_ok)     nxt = PM_SETL;
         PM_SETL: if (settle_done) nxt = PM_OPER;
         default: nxt = PM_STBY;
      endcase
      if (force_stby) nxt = PM_STBY;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= PM_STBY;
      else        state <= nxt;
   end

   // R2: hardware force always lands in Standby
   a_r2_force_stby: assert property (@(posedge clk) disable iff (!rst_n)
      force_stby |=> state == PM_STBY);

   // R3: the only exit from Standby is the settle phase
   a_r3_stby_exit: assert property (@(posedge clk) disable iff (!rst_n)
      state == PM_STBY |=> (state == PM_STBY || state == PM_SETL));

   // R7: a Standby strobe in Operating is never lost to an Idle strobe
   a_r7_stby_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_OPER && sw_stby) |=> state == PM_STBY);

   // R9: Idle holds without an unmasked interrupt or a force
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_IDLE && !irq_hit && !force_stby) |=> state == PM_IDLE);

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pwr_pkg::*;
#(
   parameter int IRQ_W       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int SETTLE_CYC  = 8,
   parameter int SETTLE_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_idle_wr,
   input  logic             sw_stby_wr,
   input  logic             pwr_fail_n,
   input  logic             user_rst_n,
   input  logic             ext_pwr_n,
   input  logic             batt_ok,
   input  logic             wake_in,
   input  logic [IRQ_W-1:0] irq_pend,
   input  logic [IRQ_W-1:0] irq_mask,
   output logic             cpu_clk_en,
   output logic             periph_en,
   output logic             dram_selfref,
   output logic             cpu_rst,
   output logic [1:0]       mode_code
);

   generate
      if (IRQ_W < 1) begin : g_bad_irq
         $error("pwr_mode_ctrl: IRQ_W must be at least 1");
      end
   endgenerate

   logic      wake_pulse;
   logic      supply_good;
   logic      wake_ok;
   logic      force_stby;
   logic      irq_hit;
   logic      settle_done;
   logic      in_settle;
   pm_state_t state;
   pm_outs_t  outs;

   pwr_wake_sync #(
      .STAGES  (SYNC_STAGES),
      .RISE_EV (1'b1)
   ) u_wake (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (wake_in),
      .pulse (wake_pulse)
   );

   assign force_stby  = !pwr_fail_n || !user_rst_n;
   assign supply_good = pwr_fail_n && (!ext_pwr_n || batt_ok);
   assign wake_ok     = wake_pulse && supply_good;
   assign irq_hit     = |(irq_pend & ~irq_mask);
   assign in_settle   = (state == PM_SETL);

   pwr_settle_cnt #(
      .LIMIT (SETTLE_CYC),
      .CNT_W (SETTLE_W)
   ) u_settle (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (in_settle),
      .done  (settle_done)
   );

   pwr_mode_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .force_stby  (force_stby),
      .sw_idle     (sw_idle_wr),
      .sw_stby     (sw_stby_wr),
      .wake_ok     (wake_ok),
      .irq_hit     (irq_hit),
      .settle_done (settle_done),
      .state       (state)
   );

   assign outs         = pm_decode(state);
   assign cpu_clk_en   = outs.cpu_clk_en;
   assign periph_en    = outs.periph_en;
   assign dram_selfref = outs.dram_selfref;
   assign cpu_rst      = outs.cpu_rst;
   assign mode_code    = outs.code;

   // R4: entry into settle only on a qualified supply
   a_r4_wake_qual: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PM_SETL && $past(state) == PM_STBY) |->
         $past(pwr_fail_n && (!ext_pwr_n || batt_ok)));

   // R6: the CPU leaves reset only at the end of the settle count
   a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cpu_rst) |-> $past(settle_done));

   // R11: the reserved mode code is never reported
   a_r11_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      mode_code != 2'b11);

   // R1: self-refresh and peripheral enable never overlap
   a_r1_selfref_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(dram_selfref && periph_en));

endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;

   localparam int IRQ_W = 4;

   localparam logic [5:0] E_OPER = 6'b00_0110;
   localparam logic [5:0] E_IDLE = 6'b01_0010;
   localparam logic [5:0] E_STBY = 6'b10_1001;
   localparam logic [5:0] E_SETL = 6'b00_1110;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sw_idle_wr = 1'b0;
   logic             sw_stby_wr = 1'b0;
   logic             pwr_fail_n = 1'b1;
   logic             user_rst_n = 1'b1;
   logic             ext_pwr_n = 1'b1;
   logic             batt_ok = 1'b1;
   logic             wake_in = 1'b0;
   logic [IRQ_W-1:0] irq_pend = '0;
   logic [IRQ_W-1:0] irq_mask = '0;
   logic             cpu_clk_en;
   logic             periph_en;
   logic             dram_selfref;
   logic             cpu_rst;
   logic [1:0]       mode_code;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   pwr_mode_ctrl #(.IRQ_W(IRQ_W)) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .sw_idle_wr   (sw_idle_wr),
      .sw_stby_wr   (sw_stby_wr),
      .pwr_fail_n   (pwr_fail_n),
      .user_rst_n   (user_rst_n),
      .ext_pwr_n    (ext_pwr_n),
      .batt_ok      (batt_ok),
      .wake_in      (wake_in),
      .irq_pend     (irq_pend),
      .irq_mask     (irq_mask),
      .cpu_clk_en   (cpu_clk_en),
      .periph_en    (periph_en),
      .dram_selfref (dram_selfref),
      .cpu_rst      (cpu_rst),
      .mode_code    (mode_code)
   );

   task automatic step(input int n);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic chk(input string req, input logic [5:0] exp);
      logic [5:0] got;
      got = {mode_code, cpu_rst, cpu_clk_en, periph_en, dram_selfref};
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic to_stby();
      user_rst_n = 1'b0;
      wake_in    = 1'b0;
      step(1);
      user_rst_n = 1'b1;
      step(3);
   endtask

   task automatic wake_full();
      wake_in = 1'b1;
      step(11);
      wake_in = 1'b0;
   endtask

   initial begin
      #4_000_000;
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      step(2);
      chk("R1 in reset", E_STBY);
      rst_n = 1'b1;
      step(1);
      chk("R1 after reset", E_STBY);

      // R5 / R6: wake timing and exact settle length
      wake_in = 1'b1;
      step(1); chk("R5 edge1", E_STBY);
      step(1); chk("R5 edge2", E_STBY);
      step(1); chk("R5 edge3 leaves", E_SETL);
      for (int k = 1; k < 8; k++) begin
         step(1);
         chk("R6 settle", E_SETL);
      end
      step(1); chk("R6 release", E_OPER);
      step(3); chk("R11 operating", E_OPER);

      // R8 / R9: Idle and interrupt mask sweep
      sw_idle_wr = 1'b1; step(1); sw_idle_wr = 1'b0;
      chk("R8 idle", E_IDLE);
      for (int p = 0; p < 16; p++) begin
         for (int m = 0; m < 16; m++) begin
            irq_pend = 4'(p);
            irq_mask = 4'(m);
            step(1);
            if ((p & ~m & 15) != 0) begin
               chk("R9 unmasked wake", E_OPER);
               irq_pend   = '0;
               sw_idle_wr = 1'b1; step(1); sw_idle_wr = 1'b0;
               chk("R8 reenter", E_IDLE);
            end else begin
               chk("R9 masked hold", E_IDLE);
            end
         end
      end
      irq_pend = 4'b0001; irq_mask = '0;
      step(1); chk("R9 exit", E_OPER);
      irq_pend = '0;

      // R7: both strobes, Standby wins
      sw_idle_wr = 1'b1; sw_stby_wr = 1'b1; step(1);
      sw_idle_wr = 1'b0; sw_stby_wr = 1'b0;
      chk("R7 stby priority", E_STBY);

      // R3: strobes and interrupts ignored in Standby
      sw_idle_wr = 1'b1; step(1); sw_idle_wr = 1'b0;
      chk("R3 idle strobe ignored", E_STBY);
      sw_stby_wr = 1'b1; irq_pend = 4'b1111; step(2);
      sw_stby_wr = 1'b0; irq_pend = '0;
      chk("R3 irq ignored", E_STBY);
      step(5);
      chk("R5 held wake no retrigger", E_STBY);
      wake_in = 1'b0; step(3);

      // R4: supply qualification sweep
      for (int v = 0; v < 8; v++) begin
         pwr_fail_n = v[2];
         ext_pwr_n  = v[1];
         batt_ok    = v[0];
         wake_in    = 1'b1;
         step(3);
         if (v[2] && (!v[1] || v[0])) chk("R4 qualified", E_SETL);
         else                         chk("R4 rejected", E_STBY);
         pwr_fail_n = 1'b1; ext_pwr_n = 1'b1; batt_ok = 1'b1;
         to_stby();
         chk("R2 user reset", E_STBY);
      end

      // R2: force from Operating and Idle
      wake_full();
      chk("R6 reached oper", E_OPER);
      pwr_fail_n = 1'b0; step(1); pwr_fail_n = 1'b1;
      chk("R2 pfail from oper", E_STBY);
      step(2);
      wake_full();
      sw_idle_wr = 1'b1; step(1); sw_idle_wr = 1'b0;
      chk("R8 idle again", E_IDLE);
      user_rst_n = 1'b0; step(1); user_rst_n = 1'b1;
      chk("R2 ureset from idle", E_STBY);
      step(2);

      // R10: abort during settle, then full restart
      wake_in = 1'b1;
      step(3); chk("R10 settle start", E_SETL);
      step(4);
      pwr_fail_n = 1'b0; step(1); pwr_fail_n = 1'b1;
      chk("R10 aborted", E_STBY);
      step(10); chk("R10 stays stby", E_STBY);
      wake_in = 1'b0; step(3);
      wake_in = 1'b1;
      step(3); chk("R10 rewake", E_SETL);
      step(7); chk("R10 full count", E_SETL);
      step(1); chk("R10 release", E_OPER);
      wake_in = 1'b0;

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule